// File: doc/BRIEF.md
# Home Directory Controller for Cluster Coherence

This block is the directory at the home node of a group of memory lines in an invalidation-based coherence scheme that spans up to eight clusters. For every line it holds a state (uncached, shared or exclusive) and a presence vector with one bit per cluster. Clusters send read, write, upgrade and eviction-hint requests over a valid/ready port. For each request the directory looks up the line, decides whether the home can supply the data or the request must be forwarded to the cluster that holds the line dirty, and writes back the new state and presence vector.

A write or upgrade that finds other clusters holding the line sends one invalidation pulse with a mask of the clusters to invalidate. It then waits for one acknowledgement from each of those clusters before it responds. While it waits, requests to that line stall, and requests to other lines that need no invalidations still go through. Each response carries the requester, the line, the state found at lookup, a forward flag with the owner, and a latency class. The latency class depends on whether the requester is the home cluster and on where the dirty copy sits.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is uncached, `reqReady` is high, and neither `rspValid` nor `invValid` is asserted. State codes on `rspPrevState` are 0 uncached, 1 shared, 2 exclusive.
- R2: A read (`reqType` 0) to an uncached or shared line is answered by the home with `rspFwd` low. The line becomes shared with the requester's presence bit added.
- R3: A read to a line held exclusive by another cluster responds with `rspFwd` high and `rspOwner` set to that owner. The line becomes shared with both the owner and the requester present.
- R4: A write (`reqType` 1) or upgrade (`reqType` 2) leaves the line exclusive with only the requester present. If any other cluster is present, a one-cycle `invValid` pulse carries `invMask` with exactly those clusters' bits.
- R5: When invalidations are issued, the response is withheld until every masked cluster has acknowledged through `ackValid`/`ackCluster`. The response appears in the cycle after the last acknowledgement.
- R6: While invalidations for a line are outstanding, requests to that line see `reqReady` low. Requests to other lines that need no invalidations are accepted.
- R7: A replacement hint (`reqType` 3) clears the sender's presence bit and produces no response and no invalidation.
- R8: A hint that clears the last presence bit returns the line to uncached.
- R9: A request from the home cluster gets latency class 0 (30 cycles), or class 1 (100 cycles) when another cluster holds the line exclusive.
- R10: A request from any other cluster gets class 2 (150 cycles) when a third cluster, neither requester nor home, holds the line exclusive, and class 1 (100 cycles) otherwise.
- R11: A request that needs no invalidations responds with a one-cycle `rspValid` in the cycle after acceptance. The response echoes the requester in `rspCluster` and the line in `rspLine`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqCluster | input | 3 | Requesting cluster |
| reqLine | input | 4 | Line index |
| reqType | input | 2 | 0 read, 1 write, 2 upgrade, 3 replacement hint |
| ackValid | input | 1 | Invalidation acknowledgement present |
| ackCluster | input | 3 | Acknowledging cluster |
| rspValid | output | 1 | Response pulse |
| rspCluster | output | 3 | Requester being answered |
| rspLine | output | 4 | Line being answered |
| rspPrevState | output | 2 | Line state found at lookup |
| rspFwd | output | 1 | Request forwarded to the dirty owner |
| rspOwner | output | 3 | Owner cluster when forwarded |
| rspLat | output | 2 | Latency class: 0 = 30, 1 = 100, 2 = 150 cycles |
| invValid | output | 1 | Invalidation pulse |
| invMask | output | 8 | Clusters to invalidate |

## Verification
The assertions check on every cycle the rules that can be stated from the ports and the pending slot alone:
- a request to the pending line is never accepted;
- an invalidation pulse and a response never coincide;
- the pending slot only empties together with a response;
- a forwarded response always reports an exclusive prior state;
- the latency class follows the home and owner positions.

Only the bench's scenarios can show the rest:
- the contents of the presence vectors, through later invalidation masks and prior states;
- the return to uncached after the last hint;
- the exact cycle of a withheld response relative to the acknowledgements;
- that a request to another line still goes through while a line waits.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    REQ_READ    = 2'd0,
    REQ_WRITE   = 2'd1,
    REQ_UPGRADE = 2'd2,
    REQ_HINT    = 2'd3
  } reqKind_t;

  typedef enum logic [1:0] {
    ST_UNCACHED = 2'd0,
    ST_SHARED   = 2'd1,
    ST_EXCL     = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    LAT_LOCAL     = 2'd0,
    LAT_TWO_HOP   = 2'd1,
    LAT_THREE_HOP = 2'd2
  } latClass_t;

  typedef struct packed {
    logic update;
    logic issueRsp;
    logic parkRsp;
    logic releaseRsp;
  } ctrlStrobe_t;
endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int N_CLUSTERS = 8,
  parameter int N_LINES    = 16,
  parameter int HOME_ID    = 0,
  localparam int CW = $clog2(N_CLUSTERS),
  localparam int LW = $clog2(N_LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CW-1:0]         reqCluster,
  input  logic [LW-1:0]         reqLine,
  input  reqKind_t              reqKind,
  input  ctrlStrobe_t           strobe,
  output logic                  needInv,
  output logic                  isHint,
  output logic [N_CLUSTERS-1:0] invNeed,
  output logic                  rspValid,
  output logic [CW-1:0]         rspCluster,
  output logic [LW-1:0]         rspLine,
  output lineState_t            rspPrevState,
  output logic                  rspFwd,
  output logic [CW-1:0]         rspOwner,
  output latClass_t             rspLat,
  output logic                  invValid,
  output logic [N_CLUSTERS-1:0] invMask
);
  lineState_t            stArr   [N_LINES];
  logic [N_CLUSTERS-1:0] presArr [N_LINES];

  lineState_t            curSt, nxtSt;
  logic [N_CLUSTERS-1:0] curPres, nxtPres, reqBit;
  logic [CW-1:0]         ownerIdx;
  logic                  exclElse, isWrite;
  latClass_t             lat;

  // parked response of a request waiting for acknowledgements
  logic [CW-1:0] parkCluster, parkOwner;
  logic [LW-1:0] parkLine;
  lineState_t    parkSt;
  logic          parkFwd;
  latClass_t     parkLat;

  always_comb begin
    curSt   = stArr[reqLine];
    curPres = presArr[reqLine];
    reqBit  = {{(N_CLUSTERS-1){1'b0}}, 1'b1} << reqCluster;
    ownerIdx = '0;
    for (int i = 0; i < N_CLUSTERS; i++)
      if (curPres[i]) ownerIdx = CW'(i);
    exclElse = (curSt == ST_EXCL) && (ownerIdx != reqCluster);
    if (reqCluster == CW'(HOME_ID))
      lat = exclElse ? LAT_TWO_HOP : LAT_LOCAL;
    else
      lat = (exclElse && ownerIdx != CW'(HOME_ID)) ? LAT_THREE_HOP : LAT_TWO_HOP;
    isWrite = (reqKind == REQ_WRITE) || (reqKind == REQ_UPGRADE);
    isHint  = (reqKind == REQ_HINT);
    invNeed = isWrite ? (curPres & ~reqBit) : '0;
    needInv = |invNeed;
    nxtSt   = curSt;
    nxtPres = curPres;
    unique case (reqKind)
      REQ_READ: begin
        nxtPres = curPres | reqBit;
        if (!(curSt == ST_EXCL && !exclElse)) nxtSt = ST_SHARED;
      end
      REQ_WRITE, REQ_UPGRADE: begin
        nxtPres = reqBit;
        nxtSt   = ST_EXCL;
      end
      default: begin
        nxtPres = curPres & ~reqBit;
        if (nxtPres == '0) nxtSt = ST_UNCACHED;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < N_LINES; l++) begin
        stArr[l]   <= ST_UNCACHED;
        presArr[l] <= '0;
      end
    end else if (strobe.update) begin
      stArr[reqLine]   <= nxtSt;
      presArr[reqLine] <= nxtPres;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0; rspCluster <= '0; rspLine <= '0; rspPrevState <= ST_UNCACHED;
      rspFwd <= 1'b0; rspOwner <= '0; rspLat <= LAT_LOCAL;
      invValid <= 1'b0; invMask <= '0;
      parkCluster <= '0; parkLine <= '0; parkSt <= ST_UNCACHED;
      parkFwd <= 1'b0; parkOwner <= '0; parkLat <= LAT_LOCAL;
    end else begin
      rspValid <= 1'b0;
      invValid <= 1'b0;
      if (strobe.issueRsp) begin
        rspValid <= 1'b1; rspCluster <= reqCluster; rspLine <= reqLine;
        rspPrevState <= curSt; rspFwd <= exclElse; rspOwner <= ownerIdx; rspLat <= lat;
      end else if (strobe.releaseRsp) begin
        rspValid <= 1'b1; rspCluster <= parkCluster; rspLine <= parkLine;
        rspPrevState <= parkSt; rspFwd <= parkFwd; rspOwner <= parkOwner; rspLat <= parkLat;
      end
      if (strobe.parkRsp) begin
        invValid <= 1'b1; invMask <= invNeed;
        parkCluster <= reqCluster; parkLine <= reqLine; parkSt <= curSt;
        parkFwd <= exclElse; parkOwner <= ownerIdx; parkLat <= lat;
      end
    end
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int N_CLUSTERS = 8,
  parameter int N_LINES    = 16,
  localparam int CW = $clog2(N_CLUSTERS),
  localparam int LW = $clog2(N_LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [LW-1:0]         reqLine,
  input  logic                  needInv,
  input  logic                  isHint,
  input  logic [N_CLUSTERS-1:0] invNeed,
  input  logic                  ackValid,
  input  logic [CW-1:0]         ackCluster,
  output logic                  reqReady,
  output ctrlStrobe_t           strobe,
  output logic                  pendValid,
  output logic [LW-1:0]         pendLine
);
  logic [N_CLUSTERS-1:0] pendMask, ackBit, maskLeft;
  logic accepted, done;

  always_comb begin
    ackBit   = {{(N_CLUSTERS-1){1'b0}}, 1'b1} << ackCluster;
    maskLeft = pendMask & ~ackBit;
    done     = pendValid && ackValid && (maskLeft == '0);
    reqReady = !done && !(pendValid && ((reqLine == pendLine) || needInv));
    accepted = reqValid && reqReady;
    strobe.update     = accepted;
    strobe.issueRsp   = accepted && !isHint && !needInv;
    strobe.parkRsp    = accepted && needInv;
    strobe.releaseRsp = done;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendLine  <= '0;
      pendMask  <= '0;
    end else if (done) begin
      pendValid <= 1'b0;
      pendMask  <= '0;
    end else if (strobe.parkRsp) begin
      pendValid <= 1'b1;
      pendLine  <= reqLine;
      pendMask  <= invNeed;
    end else if (pendValid && ackValid) begin
      pendMask <= maskLeft;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_CLUSTERS = 8,
  parameter int N_LINES    = 16,
  parameter int HOME_ID    = 0,
  localparam int CW = $clog2(N_CLUSTERS),
  localparam int LW = $clog2(N_LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [CW-1:0]         reqCluster,
  input  logic [LW-1:0]         reqLine,
  input  logic [1:0]            reqType,
  input  logic                  ackValid,
  input  logic [CW-1:0]         ackCluster,
  output logic                  rspValid,
  output logic [CW-1:0]         rspCluster,
  output logic [LW-1:0]         rspLine,
  output logic [1:0]            rspPrevState,
  output logic                  rspFwd,
  output logic [CW-1:0]         rspOwner,
  output logic [1:0]            rspLat,
  output logic                  invValid,
  output logic [N_CLUSTERS-1:0] invMask
);
  ctrlStrobe_t           strobe;
  logic                  needInv, isHint, pendValid;
  logic [LW-1:0]         pendLine;
  logic [N_CLUSTERS-1:0] invNeed;
  lineState_t            prevSt;
  latClass_t             latOut;

  assign rspPrevState = prevSt;
  assign rspLat       = latOut;

  dir_ctrl #(.N_CLUSTERS(N_CLUSTERS), .N_LINES(N_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine),
    .needInv(needInv), .isHint(isHint), .invNeed(invNeed),
    .ackValid(ackValid), .ackCluster(ackCluster), .reqReady(reqReady),
    .strobe(strobe), .pendValid(pendValid), .pendLine(pendLine)
  );

  dir_datapath #(.N_CLUSTERS(N_CLUSTERS), .N_LINES(N_LINES), .HOME_ID(HOME_ID)) u_dp (
    .clk(clk), .rstN(rstN), .reqCluster(reqCluster), .reqLine(reqLine),
    .reqKind(reqKind_t'(reqType)), .strobe(strobe), .needInv(needInv),
    .isHint(isHint), .invNeed(invNeed), .rspValid(rspValid),
    .rspCluster(rspCluster), .rspLine(rspLine), .rspPrevState(prevSt),
    .rspFwd(rspFwd), .rspOwner(rspOwner), .rspLat(latOut),
    .invValid(invValid), .invMask(invMask)
  );
endmodule

// File: rtl/dir_home_checker.sv
module dir_home_checker #(
  parameter int N_CLUSTERS = 8,
  parameter int N_LINES    = 16,
  parameter int HOME_ID    = 0,
  localparam int CW = $clog2(N_CLUSTERS),
  localparam int LW = $clog2(N_LINES)
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic [LW-1:0] reqLine,
  input logic          pendValid,
  input logic [LW-1:0] pendLine,
  input logic          rspValid,
  input logic [CW-1:0] rspCluster,
  input logic [1:0]    rspPrevState,
  input logic          rspFwd,
  input logic [CW-1:0] rspOwner,
  input logic [1:0]    rspLat,
  input logic          invValid
);
  p_hold_pending_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && reqValid && reqLine == pendLine) |-> !reqReady);

  p_inv_apart_from_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> !rspValid);

  p_pend_ends_with_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendValid) |-> rspValid);

  p_fwd_from_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFwd) |-> (rspPrevState == 2'd2 && rspOwner != rspCluster));

  p_home_lat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCluster == CW'(HOME_ID)) |-> (rspLat == (rspFwd ? 2'd1 : 2'd0)));

  p_remote_lat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCluster != CW'(HOME_ID)) |->
      (rspLat == ((rspFwd && rspOwner != CW'(HOME_ID)) ? 2'd2 : 2'd1)));
endmodule

bind dir_home_ctrl dir_home_checker #(
  .N_CLUSTERS(N_CLUSTERS), .N_LINES(N_LINES), .HOME_ID(HOME_ID)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqLine(reqLine), .pendValid(pendValid), .pendLine(pendLine),
  .rspValid(rspValid), .rspCluster(rspCluster), .rspPrevState(rspPrevState),
  .rspFwd(rspFwd), .rspOwner(rspOwner), .rspLat(rspLat), .invValid(invValid)
);

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;
  localparam int NC = 8;
  localparam int NL = 16;
  localparam int HOME = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [2:0] reqCluster = '0;
  logic [3:0] reqLine = '0;
  logic [1:0] reqType = '0;
  logic ackValid = 1'b0;
  logic [2:0] ackCluster = '0;
  logic rspValid, rspFwd, invValid;
  logic [2:0] rspCluster, rspOwner;
  logic [3:0] rspLine;
  logic [1:0] rspPrevState, rspLat;
  logic [7:0] invMask;

  int nVec = 0, nBad = 0;
  bit finished = 0;

  int         mSt   [NL];
  logic [7:0] mPres [NL];

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.N_CLUSTERS(NC), .N_LINES(NL), .HOME_ID(HOME)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCluster(reqCluster), .reqLine(reqLine), .reqType(reqType),
    .ackValid(ackValid), .ackCluster(ackCluster), .rspValid(rspValid),
    .rspCluster(rspCluster), .rspLine(rspLine), .rspPrevState(rspPrevState),
    .rspFwd(rspFwd), .rspOwner(rspOwner), .rspLat(rspLat),
    .invValid(invValid), .invMask(invMask)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ownerOf(input logic [7:0] p);
    int o = 0;
    for (int i = 0; i < NC; i++) if (p[i]) o = i;
    return o;
  endfunction

  task automatic expectFor(input int cl, input int ln, input int ty,
                           output int eSt, output int eFwd, output int eOwn,
                           output int eLat, output logic [7:0] eInv);
    int own;
    own  = ownerOf(mPres[ln]);
    eSt  = mSt[ln];
    eFwd = (mSt[ln] == 2 && own != cl) ? 1 : 0;
    eOwn = own;
    if (cl == HOME) eLat = eFwd ? 1 : 0;
    else eLat = (eFwd && own != HOME) ? 2 : 1;
    eInv = (ty == 1 || ty == 2) ? (mPres[ln] & ~(8'd1 << cl)) : 8'd0;
  endtask

  task automatic modelUpdate(input int cl, input int ln, input int ty);
    logic [7:0] b;
    b = 8'd1 << cl;
    if (ty == 0) begin
      if (!(mSt[ln] == 2 && ownerOf(mPres[ln]) == cl)) mSt[ln] = 1;
      mPres[ln] = mPres[ln] | b;
    end else if (ty == 3) begin
      mPres[ln] = mPres[ln] & ~b;
      if (mPres[ln] == 0) mSt[ln] = 0;
    end else begin
      mPres[ln] = b; mSt[ln] = 2;
    end
  endtask

  task automatic checkRsp(input string tag, input int cl, input int ln,
                          input int eSt, input int eFwd, input int eOwn, input int eLat);
    chk(rspValid === 1'b1, "R11", {tag, " rspValid"}, int'(rspValid), 1);
    chk(rspCluster == cl && rspLine == ln, "R11", {tag, " echo"}, int'(rspLine), ln);
    chk(rspPrevState == eSt, tag, "prevState", int'(rspPrevState), eSt);
    chk(rspFwd == eFwd, (eFwd != 0) ? "R3" : "R2", {tag, " fwd"}, int'(rspFwd), eFwd);
    if (eFwd != 0) chk(rspOwner == eOwn, "R3", "owner", int'(rspOwner), eOwn);
    chk(rspLat == eLat, (cl == HOME) ? "R9" : "R10", {tag, " lat"}, int'(rspLat), eLat);
  endtask

  task automatic ackAll(input int cl, input int ln, input logic [7:0] eInv,
                        input int eSt, input int eFwd, input int eOwn, input int eLat);
    int left;
    left = $countones(eInv);
    for (int i = 0; i < NC; i++) begin
      if (eInv[i]) begin
        ackValid = 1'b1; ackCluster = 3'(i);
        @(negedge clk);
        ackValid = 1'b0;
        left--;
        if (left > 0) chk(rspValid === 1'b0, "R5", "early response", int'(rspValid), 0);
        else checkRsp("R5", cl, ln, eSt, eFwd, eOwn, eLat);
      end
    end
  endtask

  task automatic doReq(input int cl, input int ln, input int ty, input string tag);
    int eSt, eFwd, eOwn, eLat;
    logic [7:0] eInv;
    expectFor(cl, ln, ty, eSt, eFwd, eOwn, eLat, eInv);
    @(negedge clk);
    reqValid = 1'b1; reqCluster = 3'(cl); reqLine = 4'(ln); reqType = 2'(ty);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (ty == 3) begin
      chk(rspValid === 1'b0 && invValid === 1'b0, "R7", "hint produced output",
          int'(rspValid), 0);
    end else if (eInv != 0) begin
      chk(invValid === 1'b1 && invMask == eInv, "R4", "invMask", int'(invMask), int'(eInv));
      chk(rspValid === 1'b0, "R5", "response with inv", int'(rspValid), 0);
      ackAll(cl, ln, eInv, eSt, eFwd, eOwn, eLat);
    end else begin
      chk(invValid === 1'b0, "R4", "spurious inv", int'(invValid), 0);
      checkRsp(tag, cl, ln, eSt, eFwd, eOwn, eLat);
      @(negedge clk);
      chk(rspValid === 1'b0, "R11", "pulse length", int'(rspValid), 0);
    end
    modelUpdate(cl, ln, ty);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int eSt, eFwd, eOwn, eLat;
    logic [7:0] eInv;
    void'($urandom(32'h5eed));
    for (int l = 0; l < NL; l++) begin mSt[l] = 0; mPres[l] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1 && rspValid === 1'b0 && invValid === 1'b0, "R1", "reset outputs",
        int'(rspValid), 0);

    doReq(3, 3, 0, "R1");            // uncached line read
    doReq(0, 1, 0, "R9");            // home read, local class
    doReq(2, 1, 1, "R4");            // write invalidates home
    doReq(0, 1, 0, "R9");            // home read of remote dirty
    doReq(5, 2, 1, "R4");
    doReq(3, 2, 0, "R10");           // third party dirty
    doReq(0, 7, 1, "R4");
    doReq(4, 7, 0, "R10");           // home owns, two hops
    doReq(3, 8, 0, "R2");
    doReq(4, 8, 0, "R2");
    doReq(3, 8, 3, "R7");
    doReq(6, 8, 2, "R7");            // upgrade sees only cluster 4
    doReq(6, 8, 3, "R8");
    doReq(1, 8, 0, "R8");            // prior state must be uncached

    // R6: pending line held, other line proceeds
    doReq(1, 5, 0, "R2");
    doReq(2, 5, 0, "R2");
    expectFor(3, 5, 1, eSt, eFwd, eOwn, eLat, eInv);
    @(negedge clk);
    reqValid = 1'b1; reqCluster = 3'd3; reqLine = 4'd5; reqType = 2'd1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(invValid === 1'b1 && invMask == eInv, "R4", "pending inv", int'(invMask), int'(eInv));
    modelUpdate(3, 5, 1);
    reqValid = 1'b1; reqCluster = 3'd4; reqLine = 4'd5; reqType = 2'd0;
    #1;
    chk(reqReady === 1'b0, "R6", "same line ready", int'(reqReady), 0);
    @(negedge clk);
    chk(rspValid === 1'b0, "R6", "held request answered", int'(rspValid), 0);
    reqLine = 4'd6;
    #1;
    chk(reqReady === 1'b1, "R6", "other line ready", int'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid === 1'b1 && rspLine == 4'd6, "R6", "other line answered", int'(rspLine), 6);
    modelUpdate(4, 6, 0);
    ackAll(3, 5, eInv, eSt, eFwd, eOwn, eLat);

    for (int n = 0; n < 400; n++)
      doReq(int'($urandom % NC), int'($urandom % 4), int'($urandom % 4), "R2");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule